// File: doc/BRIEF.md
# Frame Serializer with Bit Stuffing and Arbitration

This block sends one CAN-style data or remote frame onto a single-wire bus, one bit per bit-time strobe. A start pulse captures the frame fields: standard or extended identifier format, the remote flag, a 29-bit identifier, a 4-bit length code, up to eight data bytes and a precomputed 15-bit CRC. The block then drives a dominant start bit, the header, the data field and the CRC. From the start bit through the last CRC bit it inserts a complementary stuff bit after every run of five equal bits. A fixed recessive trailer of thirteen bit times follows, and this trailer is not stuffed.

While the identifier field is on the bus, every recessive bit the block drives is compared with the sampled bus value. If a dominant value comes back, the block has lost arbitration. It then drives only recessive bits and waits until the bus has stayed recessive long enough to count as idle. Only after that can a new frame be started. CRC generation and frame reception are not part of this block.

Top module: `frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is 1 (recessive), `busy` is 0 and `arb_lost` is 0 (until a loss occurs).
- R2: A `start` pulse while `busy` is 0 makes `busy` 1 and `tx` 0 (the dominant start bit) on the next clock. A `start` pulse while `busy` is 1 is ignored: the frame in flight continues unchanged.
- R3: In standard format (`ext_fmt`=0), the bits after the start bit are id[10:0] MSB first, the remote flag, two 0 bits, then len[3:0] MSB first.
- R4: In extended format (`ext_fmt`=1), the bits after the start bit are id[28:18], two 1 bits, id[17:0], the remote flag, two 0 bits, then len[3:0]. All fields are sent MSB first.
- R5: The data field holds min(len, MAX_BYTES) bytes. Byte 0 (`data[7:0]`) goes first and byte k is `data[8k+7:8k]`, each sent MSB first. When `rtr`=1 no data field is sent, whatever the length.
- R6: The 15-bit CRC follows the data field, or the header when there is no data field, and is sent MSB first.
- R7: From the start bit through the last CRC bit, after five consecutive equal transmitted bits the next bit is the opposite value. Stuff bits count toward later runs, and a stuff bit is also inserted after the final CRC bits when they complete a run of five.
- R8: After the CRC (and any closing stuff bit), 13 recessive bit times are sent without stuffing. `busy` falls at the strobe that ends the last of them.
- R9: `tx` changes only on a clock with `bit_tick`=1, or on the clock that accepts `start`.
- R10: Arbitration is lost when the block drives a recessive bit and `rx`=0 at a strobe, while the most recent frame bit is inside the arbitration field. That field is frame bits 1–12 in standard format and 1–32 in extended format, counting the start bit as 0. On a loss, `arb_lost` becomes 1 and `tx` stays 1 for the rest of the attempt.
- R11: A dominant `rx` outside the arbitration field has no effect: the frame is sent in full and `arb_lost` stays 0.
- R12: After a loss, `busy` stays 1 until `rx` has been 1 at IDLE_BITS consecutive strobes, and then falls. A dominant sample restarts that count. `arb_lost` stays 1 until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame; fields are captured on this clock |
| bit_tick | input | 1 | One-clock strobe per bit time; also the bus sample instant |
| ext_fmt | input | 1 | 1 selects the extended identifier format |
| rtr | input | 1 | 1 sends a remote frame (no data field) |
| id | input | 29 | Identifier; standard format uses id[10:0] |
| len | input | 4 | Length code |
| data | input | 8*MAX_BYTES | Data bytes, byte k at [8k+7:8k] |
| crc | input | 15 | Precomputed CRC sequence |
| rx | input | 1 | Sampled bus value |
| tx | output | 1 | Bus drive, 1 = recessive |
| busy | output | 1 | Frame or post-loss wait in progress |
| arb_lost | output | 1 | Arbitration was lost in the latest attempt |

## Verification
The bench builds the block with MAX_BYTES=8 and IDLE_BITS=11. Eight bytes gives a maximum-length data field, so a length code above eight exercises the clamp. Eleven idle bits keeps the post-loss wait short enough to count it bit by bit. With an eight-byte field of zeros or ones, long stuffed runs reach the CRC boundary. The extended format places arbitration bits past bit 12, which separates the two window sizes.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_BODY    = 2'd1,
    S_TRAIL   = 2'd2,
    S_BACKOFF = 2'd3
  } ftx_state_e;

  localparam int STD_HDR    = 18;  // header bits after the start bit
  localparam int EXT_HDR    = 38;
  localparam int STD_ARB    = 12;  // last frame-bit index inside arbitration
  localparam int EXT_ARB    = 32;
  localparam int CRC_BITS   = 15;
  localparam int TRAIL_BITS = 13;
  localparam int STUFF_RUN  = 5;

  // Number of data bytes actually sent.
  function automatic int byte_count(input logic rtr_f, input logic [3:0] len_f,
                                    input int max_bytes);
    if (rtr_f) return 0;
    if (int'(len_f) > max_bytes) return max_bytes;
    return int'(len_f);
  endfunction

  function automatic int hdr_span(input logic ext_f);
    return ext_f ? EXT_HDR : STD_HDR;
  endfunction

  function automatic int arb_span(input logic ext_f);
    return ext_f ? EXT_ARB : STD_ARB;
  endfunction

endpackage

// File: rtl/ftx_assemble.sv
module ftx_assemble
  import frame_tx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int DW        = 8 * MAX_BYTES,
  parameter int VW        = EXT_HDR + DW + CRC_BITS,
  parameter int IW        = $clog2(VW + 2)
) (
  input  logic          ext_fmt,
  input  logic          rtr,
  input  logic [28:0]   id,
  input  logic [3:0]    len,
  input  logic [DW-1:0] data,
  input  logic [14:0]   crc,
  output logic [VW-1:0] frame_vec,   // bits after the start bit, left aligned
  output logic [IW-1:0] frame_bits   // count of valid bits in frame_vec
);

  localparam int PAD = EXT_HDR - STD_HDR;

  // Left-aligned data field with byte 0 at the top, unused bytes cleared,
  // followed at once by the CRC.
  function automatic logic [DW+CRC_BITS-1:0] body_field(
      input logic [DW-1:0] d, input logic [14:0] c, input int nb);
    logic [DW-1:0]          df;
    logic [DW-1:0]          keep;
    logic [DW+CRC_BITS-1:0] crc_pos;
    for (int b = 0; b < MAX_BYTES; b++) df[DW-1-8*b -: 8] = d[8*b +: 8];
    keep    = ~({DW{1'b1}} >> (8 * nb));
    crc_pos = {{DW{1'b0}}, c} << (DW - 8 * nb);
    return {df & keep, {CRC_BITS{1'b0}}} | crc_pos;
  endfunction

  logic [STD_HDR-1:0]     hdr_s;
  logic [EXT_HDR-1:0]     hdr_e;
  logic [DW+CRC_BITS-1:0] body;
  int                     nbytes;

  always_comb begin
    nbytes = byte_count(rtr, len, MAX_BYTES);
    hdr_s  = {id[10:0], rtr, 2'b00, len};
    hdr_e  = {id[28:18], 2'b11, id[17:0], rtr, 2'b00, len};
    body   = body_field(data, crc, nbytes);
    if (ext_fmt) frame_vec = {hdr_e, body};
    else         frame_vec = {hdr_s, body, {PAD{1'b0}}};
    frame_bits = IW'(hdr_span(ext_fmt) + 8 * nbytes + CRC_BITS);
  end

endmodule

// File: rtl/ftx_stuffer.sv
module ftx_stuffer
  import frame_tx_pkg::*;
(
  input  logic [2:0] run_len,   // equal-bit run ending with the bit on the wire
  input  logic       last_bit,  // bit now on the wire
  input  logic       cand_bit,  // next frame bit if no stuff bit is due
  output logic       insert,    // next bit must be the complement of last_bit
  output logic [2:0] run_next
);

  always_comb begin
    insert = (run_len == 3'(STUFF_RUN));
    if (insert)                    run_next = 3'd1;
    else if (cand_bit == last_bit) run_next = run_len + 3'd1;
    else                           run_next = 3'd1;
  end

endmodule

// File: rtl/ftx_arbiter.sv
module ftx_arbiter
  import frame_tx_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          ext_fmt,
  input  logic [IW-1:0] frame_idx,  // index of the latest frame bit, start bit = 0
  input  logic          active,     // strobe while the frame body is on the wire
  input  logic          tx_bit,
  input  logic          rx_bit,
  output logic          in_window,
  output logic          lose
);

  always_comb begin
    in_window = (frame_idx != '0) && (frame_idx <= IW'(arb_span(ext_fmt)));
    lose      = active && in_window && tx_bit && !rx_bit;
  end

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int IDLE_BITS = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   bit_tick,
  input  logic                   ext_fmt,
  input  logic                   rtr,
  input  logic [28:0]            id,
  input  logic [3:0]             len,
  input  logic [8*MAX_BYTES-1:0] data,
  input  logic [14:0]            crc,
  input  logic                   rx,
  output logic                   tx,
  output logic                   busy,
  output logic                   arb_lost
);

  localparam int DW      = 8 * MAX_BYTES;
  localparam int VW      = EXT_HDR + DW + CRC_BITS;
  localparam int IW      = $clog2(VW + 2);
  localparam int CNT_MAX = (TRAIL_BITS > IDLE_BITS) ? TRAIL_BITS : IDLE_BITS;
  localparam int CW      = $clog2(CNT_MAX + 1);

  ftx_state_e    state_q;
  logic [VW-1:0] vec_q;
  logic [IW-1:0] remain_q;
  logic [IW-1:0] idx_q;
  logic [2:0]    run_q;
  logic          last_q;
  logic          tx_q;
  logic          ext_q;
  logic          lost_q;
  logic [CW-1:0] cnt_q;

  logic [VW-1:0] new_vec;
  logic [IW-1:0] new_bits;
  logic          insert;
  logic [2:0]    run_next;
  logic          in_window;
  logic          lose;

  // Named internal events
  logic accept_evt, stuff_evt, frame_evt, trail_done_evt, idle_seen_evt;

  ftx_assemble #(.MAX_BYTES(MAX_BYTES), .DW(DW), .VW(VW), .IW(IW)) u_asm (
    .ext_fmt   (ext_fmt),
    .rtr       (rtr),
    .id        (id),
    .len       (len),
    .data      (data),
    .crc       (crc),
    .frame_vec (new_vec),
    .frame_bits(new_bits)
  );

  ftx_stuffer u_stuff (
    .run_len (run_q),
    .last_bit(last_q),
    .cand_bit(vec_q[VW-1]),
    .insert  (insert),
    .run_next(run_next)
  );

  ftx_arbiter #(.IW(IW)) u_arb (
    .ext_fmt  (ext_q),
    .frame_idx(idx_q),
    .active   (bit_tick && state_q == S_BODY),
    .tx_bit   (tx_q),
    .rx_bit   (rx),
    .in_window(in_window),
    .lose     (lose)
  );

  always_comb begin
    accept_evt     = start && state_q == S_IDLE;
    stuff_evt      = state_q == S_BODY && insert && !lose;
    frame_evt      = state_q == S_BODY && !insert && !lose && remain_q != '0;
    trail_done_evt = state_q == S_TRAIL && cnt_q == CW'(TRAIL_BITS - 1);
    idle_seen_evt  = state_q == S_BACKOFF && rx && cnt_q == CW'(IDLE_BITS - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      vec_q    <= '0;
      remain_q <= '0;
      idx_q    <= '0;
      run_q    <= 3'd1;
      last_q   <= 1'b1;
      tx_q     <= 1'b1;
      ext_q    <= 1'b0;
      lost_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept_evt) begin
          state_q  <= S_BODY;
          vec_q    <= new_vec;
          remain_q <= new_bits;
          idx_q    <= '0;
          run_q    <= 3'd1;
          last_q   <= 1'b0;
          tx_q     <= 1'b0;
          ext_q    <= ext_fmt;
          lost_q   <= 1'b0;
        end
        S_BODY: if (bit_tick) begin
          if (lose) begin
            state_q <= S_BACKOFF;
            tx_q    <= 1'b1;
            lost_q  <= 1'b1;
            cnt_q   <= '0;
          end else if (stuff_evt) begin
            tx_q   <= ~last_q;
            last_q <= ~last_q;
            run_q  <= run_next;
          end else if (frame_evt) begin
            tx_q     <= vec_q[VW-1];
            last_q   <= vec_q[VW-1];
            run_q    <= run_next;
            vec_q    <= vec_q << 1;
            remain_q <= remain_q - 1'b1;
            idx_q    <= idx_q + 1'b1;
          end else begin
            state_q <= S_TRAIL;
            tx_q    <= 1'b1;
            cnt_q   <= '0;
          end
        end
        S_TRAIL: if (bit_tick) begin
          if (trail_done_evt) state_q <= S_IDLE;
          else                cnt_q   <= cnt_q + 1'b1;
        end
        S_BACKOFF: if (bit_tick) begin
          if (!rx)                cnt_q   <= '0;
          else if (idle_seen_evt) state_q <= S_IDLE;
          else                    cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tx       = tx_q;
  assign busy     = state_q != S_IDLE;
  assign arb_lost = lost_q;

  // R2: an accepted start puts the dominant start bit on the wire next clock
  p_sof_dominant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !tx));

  // R1: recessive whenever nothing is in progress
  p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  // R9: the wire only moves on a strobe or an accepted start
  p_tx_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !(start && !busy)) |=> $stable(tx));

  // R7: a stuff bit is always the complement of the bit before it
  p_stuff_flips_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && stuff_evt) |=> (tx != $past(tx)));

  // R7: runs never exceed the stuffing limit inside the stuffed region
  p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BODY) |-> (run_q != 3'd0 && run_q <= 3'(STUFF_RUN)));

  // R10: after a loss only recessive is driven
  p_recessive_after_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> tx);

  // R10: a loss needs a recessive drive met by a dominant sample
  p_loss_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> ($past(tx) && !$past(rx) && $past(bit_tick)));

  // R12: the post-loss wait ends only on a recessive sample
  p_backoff_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BACKOFF && bit_tick && !rx) |=> busy);

endmodule

// File: tb/frame_tx_bench.sv
module frame_tx_bench;

  localparam int MAXB = 8;
  localparam int IDLE = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          bit_tick = 1'b0;
  logic          ext_fmt = 1'b0;
  logic          rtr = 1'b0;
  logic [28:0]   id = '0;
  logic [3:0]    len = '0;
  logic [63:0]   data = '0;
  logic [14:0]   crc = '0;
  logic          rx = 1'b1;
  logic          tx, busy, arb_lost;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // expected transmit stream
  bit xb[0:299];
  int xf[0:299];
  bit xs[0:299];
  int xn;

  frame_tx #(.MAX_BYTES(MAXB), .IDLE_BITS(IDLE)) u_frame_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick),
    .ext_fmt(ext_fmt), .rtr(rtr), .id(id), .len(len), .data(data), .crc(crc),
    .rx(rx), .tx(tx), .busy(busy), .arb_lost(arb_lost)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one bit time: strobe for one clock, then one quiet clock
  task automatic tick(input logic rxv);
    rx = rxv; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; rx = 1'b1;
    @(negedge clk);
  endtask

  // Reference stream from the requirement text
  task automatic build_expected();
    bit raw[0:199];
    int nraw = 0;
    int nb, run;
    bit prev;
    nb = rtr ? 0 : ((len > 4'd8) ? 8 : int'(len));
    raw[nraw++] = 1'b0;
    if (ext_fmt) begin
      for (int k = 28; k >= 18; k--) raw[nraw++] = id[k];
      raw[nraw++] = 1'b1; raw[nraw++] = 1'b1;
      for (int k = 17; k >= 0; k--) raw[nraw++] = id[k];
    end else begin
      for (int k = 10; k >= 0; k--) raw[nraw++] = id[k];
    end
    raw[nraw++] = rtr; raw[nraw++] = 1'b0; raw[nraw++] = 1'b0;
    for (int k = 3; k >= 0; k--) raw[nraw++] = len[k];
    for (int b = 0; b < nb; b++)
      for (int k = 7; k >= 0; k--) raw[nraw++] = data[8*b + k];
    for (int k = 14; k >= 0; k--) raw[nraw++] = crc[k];
    xn = 0; run = 0; prev = 1'b1;
    for (int j = 0; j < nraw; j++) begin
      run = (xn > 0 && raw[j] == prev) ? run + 1 : 1;
      prev = raw[j];
      xb[xn] = raw[j]; xf[xn] = j; xs[xn] = 1'b0; xn++;
      if (run == 5) begin
        prev = ~prev; run = 1;
        xb[xn] = prev; xf[xn] = j; xs[xn] = 1'b1; xn++;
      end
    end
    for (int t = 0; t < 13; t++) begin
      xb[xn] = 1'b1; xf[xn] = -1; xs[xn] = 1'b0; xn++;
    end
  endtask

  // Send one frame; lf = frame-bit index forced dominant on rx (-1: none)
  task automatic run_frame(input string req, input int lf, input bit poke_start);
    int pos = -1, errs = 0, first_bad = -1, win;
    bit exp_loss;
    build_expected();
    win = ext_fmt ? 32 : 12;
    for (int i = 0; i < xn; i++)
      if (pos < 0 && lf >= 0 && xf[i] == lf && !xs[i]) pos = i;
    exp_loss = pos >= 0 && xb[pos] && lf >= 1 && lf <= win;

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && tx === 1'b0, "R2", "start bit {busy,tx}", {busy, tx}, 2);
    check(arb_lost === 1'b0, "R1", "arb_lost cleared at start", arb_lost, 0);

    for (int i = 0; i < xn; i++) begin
      if (poke_start && i == 25) begin
        id = ~id; ext_fmt = ~ext_fmt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        id = ~id; ext_fmt = ~ext_fmt;
      end
      if (tx !== xb[i]) begin errs++; if (first_bad < 0) first_bad = i; end
      if (i == xn - 1 && !exp_loss)
        check(busy === 1'b1, "R8", "busy during last trailer bit", busy, 1);
      tick((i == pos) ? 1'b0 : tx);
      if (tx !== xb[i] && xb[i] == xb[i] && i + 1 < xn && tx !== xb[i + 1] &&
          !(exp_loss && i == pos)) begin
        // next bit is compared at the top of the next iteration
      end
      if (exp_loss && i == pos) break;
    end
    if (exp_loss) begin
      check(errs == 0, req, "stream up to loss mismatches", first_bad, -1);
      check(arb_lost === 1'b1 && tx === 1'b1, "R10", "{arb_lost,tx} after loss",
            {arb_lost, tx}, 3);
      // a dominant sample restarts the idle count
      for (int t = 0; t < 6; t++) tick(1'b1);
      tick(1'b0);
      for (int t = 0; t < IDLE - 1; t++) tick(1'b1);
      check(busy === 1'b1 && tx === 1'b1, "R12", "still waiting before idle",
            {busy, tx}, 3);
      tick(1'b1);
      check(busy === 1'b0, "R12", "busy after idle bits", busy, 0);
      check(arb_lost === 1'b1, "R12", "arb_lost held after wait", arb_lost, 1);
    end else begin
      check(errs == 0, req, "stream mismatches (first bad index)", first_bad, -1);
      check(busy === 1'b0 && tx === 1'b1, "R8", "{busy,tx} after trailer",
            {busy, tx}, 1);
      check(arb_lost === 1'b0, (lf >= 0) ? "R11" : "R1", "no arbitration loss",
            arb_lost, 0);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check(tx === 1'b1, "R1", "tx after reset", tx, 1);
    check(busy === 1'b0, "R1", "busy after reset", busy, 0);
    check(arb_lost === 1'b0, "R1", "arb_lost after reset", arb_lost, 0);
    tick(1'b1);
    check(tx === 1'b1 && busy === 1'b0, "R9", "strobe while idle", {busy, tx}, 1);
  endtask

  task automatic t_std_data();  // R3 R5 R6 R7 R8 R9
    ext_fmt = 0; rtr = 0; id = 29'h5A3; len = 4'd2;
    data = 64'h0000_0000_0000_C35A; crc = 15'h2B6D;
    run_frame("R3", -1, 1'b0);
  endtask

  task automatic t_ext_data();  // R4 R5
    ext_fmt = 1; rtr = 0; id = 29'h1ABC_DEF1; len = 4'd8;
    data = 64'h0123_4567_89AB_CDEF; crc = 15'h5555;
    run_frame("R4", -1, 1'b0);
  endtask

  task automatic t_remote();  // R5 R6
    ext_fmt = 0; rtr = 1; id = 29'h2F0; len = 4'd5;
    data = 64'hFFFF_FFFF_FFFF_FFFF; crc = 15'h1234;
    run_frame("R5", -1, 1'b0);
    ext_fmt = 1; id = 29'h0F0F_0F0F;
    run_frame("R5", -1, 1'b0);
  endtask

  task automatic t_clamp();  // R5
    ext_fmt = 0; rtr = 0; id = 29'h155; len = 4'd13;
    data = 64'hA5A5_0F0F_3C3C_9696; crc = 15'h0F0F;
    run_frame("R5", -1, 1'b0);
  endtask

  task automatic t_stuff_runs();  // R7
    ext_fmt = 0; rtr = 0; id = 29'h0; len = 4'd8; data = '0; crc = 15'h0;
    run_frame("R7", -1, 1'b0);
    ext_fmt = 1; id = 29'h1FFF_FFFF; data = '1; crc = 15'h7FFF;
    run_frame("R7", -1, 1'b0);
  endtask

  task automatic t_start_ignored();  // R2
    ext_fmt = 0; rtr = 0; id = 29'h3C7; len = 4'd3;
    data = 64'h0000_0000_0011_2233; crc = 15'h4321;
    run_frame("R2", -1, 1'b1);
  endtask

  task automatic t_loss_std();  // R10 R12: standard window ends at the remote flag
    ext_fmt = 0; rtr = 1; id = 29'h7F0; len = 4'd0; crc = 15'h1111;
    run_frame("R10", 12, 1'b0);
  endtask

  task automatic t_loss_ext_late();  // R10: bit 13 only arbitrates in extended
    ext_fmt = 1; rtr = 0; id = 29'h0000_0000; len = 4'd1;
    data = 64'h7E; crc = 15'h0ACE;
    run_frame("R10", 13, 1'b0);
    ext_fmt = 1; rtr = 1; id = 29'h0AAA_AAAA;
    run_frame("R10", 32, 1'b0);
  endtask

  task automatic t_outside_window();  // R11
    ext_fmt = 0; rtr = 0; id = 29'h001; len = 4'd1;
    data = 64'h80; crc = 15'h6000;
    run_frame("R11", 19, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_std_data();
    t_ext_data();
    t_remote();
    t_clamp();
    t_stuff_runs();
    t_start_ignored();
    t_loss_std();
    t_loss_ext_late();
    t_outside_window();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule